// File: doc/BRIEF.md
# Burst Memory Slave with Queued Reads

This block is a small on-chip memory behind an AXI4-style slave port with five independent valid/ready channels: write address, write data, write response, read address and read data. A write request names a start address, a beat count and an ID. The data beats that follow are merged into memory one byte lane at a time under the write strobes. The burst closes on the last-beat flag, and a single response then carries the ID back together with an OKAY or SLVERR status.

The read side holds a small queue of pending read requests. A master can hand over the next read address while an earlier burst is still streaming out. Queued requests are served strictly in arrival order, and each burst's final beat is followed at once by the first beat of the next one. Each read beat is registered before it is presented, so its data stays put while the master stalls. Accesses beyond the memory size are answered with SLVERR beats. The burst length of such an access is never shortened.

Top module: `axmem_slave`

## Requirements
- R1: A write address is accepted (awready high) only when no write burst is in progress. The data beats follow, then exactly one response is raised, and bvalid, bid and bresp hold steady until bready is sampled high.
- R2: Strobe bit i enables data bits 8i+7:8i of a beat. A byte whose strobe bit is clear keeps its previous contents, including when every strobe bit is clear.
- R3: A write burst of awlen+1 beats stores beat k at byte address awaddr+4k (4 = bus width in bytes). The two low address bits do not select a lane.
- R4: A read burst returns arlen+1 beats from consecutive word addresses. rlast is high on the final beat only, and rresp is given per beat.
- R5: Up to two read requests may be pending. They are served in arrival order, and with rready held high the first beat of a queued request follows the previous request's rlast beat with no idle cycle.
- R6: arready is low while two read requests are pending, and a read address held valid in that time is accepted only after space frees up.
- R7: bid equals the awid of the write it answers, and rid equals the arid of the read it answers.
- R8: A beat whose byte address is 256 or above (the default memory size) is out of range. On a write, that beat is discarded and the burst's bresp is SLVERR (2'b10). On a read, that beat returns zero data with rresp SLVERR. Otherwise the response is OKAY (2'b00), and the beat count is never shortened.
- R9: If wlast arrives before the expected final beat, the burst ends on that beat. If wlast is missing on the expected final beat, the burst ends there anyway. Either mismatch gives bresp SLVERR, and the beats already accepted are kept.
- R10: While rvalid is high and rready is low, rvalid, rdata, rid, rresp and rlast stay unchanged.
- R11: rst_n low asynchronously clears bvalid, rvalid and wready, drops all pending read requests and any partial write, and leaves the memory contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awid | input | 4 | Write request ID |
| awaddr | input | 12 | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write beat data |
| wstrb | input | 4 | Write byte-lane enables |
| wlast | input | 1 | Final write beat flag |
| wvalid | input | 1 | Write beat valid |
| wready | output | 1 | Write beat ready |
| bid | output | 4 | Response ID |
| bresp | output | 2 | Write status, 00 OKAY, 10 SLVERR |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| arid | input | 4 | Read request ID |
| araddr | input | 12 | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rid | output | 4 | Read beat ID |
| rdata | output | 32 | Read beat data |
| rresp | output | 2 | Read beat status, 00 OKAY, 10 SLVERR |
| rlast | output | 1 | Final read beat flag |
| rvalid | output | 1 | Read beat valid |
| rready | input | 1 | Read beat ready |

## Verification
Every ready output comes from registered state, so the bench drives at falling edges and reads each ready there to know whether the coming rising edge completes a handshake. bvalid is due one edge after the last write-data handshake. A read's first beat is due on the second rising edge after its address handshake, and later beats arrive on every edge where rready is high. Because of this, the collector checks the beats of back-to-back requests without waiting, which exposes any idle cycle between bursts. Stall, full-queue and reset checks all sample at the falling edge after the edge that caused them.

// File: rtl/axmem_pkg.sv
package axmem_pkg;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   typedef enum logic [1:0] {
      WS_ADDR,
      WS_DATA,
      WS_RESP
   } wr_state_e;
endpackage

// File: rtl/axmem_rdq.sv
module axmem_rdq #(
   parameter int W     = 24,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("axmem_rdq: DEPTH must be at least 2");
   end

   logic [W-1:0]     slot [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= step(wp);
         if (pop)  rp <= step(rp);
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign dout  = slot[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   // R6: no request is written into a full queue
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R5: a request is only retired while one is pending
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
endmodule

// File: rtl/axmem_wr.sv
module axmem_wr
   import axmem_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int ID_W      = 4,
   parameter int LEN_W     = 8,
   parameter int MEM_BYTES = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ID_W-1:0]     awid,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic [LEN_W-1:0]    awlen,
   input  logic                awvalid,
   output logic                awready,
   input  logic                wlast,
   input  logic                wvalid,
   output logic                wready,
   output logic [ID_W-1:0]     bid,
   output logic [1:0]          bresp,
   output logic                bvalid,
   input  logic                bready,
   output logic                mem_we,
   output logic [$clog2(MEM_BYTES/(DATA_W/8))-1:0] mem_idx
);
   localparam int STRB_W = DATA_W / 8;
   localparam int LSB    = $clog2(STRB_W);
   localparam int IDX_W  = $clog2(MEM_BYTES / STRB_W);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_BYTES);

   wr_state_e          st;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   len_q, cnt_q;
   logic [ID_W-1:0]    id_q;
   logic               err_q;
   logic               in_rng, final_beat;

   assign in_rng     = ({1'b0, addr_q} < LIMIT);
   assign final_beat = (cnt_q == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= WS_ADDR;
         addr_q <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         id_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         unique case (st)
            WS_ADDR: if (awvalid) begin
               addr_q <= awaddr;
               len_q  <= awlen;
               id_q   <= awid;
               cnt_q  <= '0;
               err_q  <= 1'b0;
               st     <= WS_DATA;
            end
            WS_DATA: if (wvalid) begin
               addr_q <= addr_q + ADDR_W'(STRB_W);
               cnt_q  <= cnt_q + 1'b1;
               if (!in_rng || (wlast != final_beat)) err_q <= 1'b1;
               if (wlast || final_beat) st <= WS_RESP;
            end
            WS_RESP: if (bready) st <= WS_ADDR;
            default: st <= WS_ADDR;
         endcase
      end
   end

   assign awready = (st == WS_ADDR);
   assign wready  = (st == WS_DATA);
   assign bvalid  = (st == WS_RESP);
   assign bid     = id_q;
   assign bresp   = err_q ? RESP_SLVERR : RESP_OKAY;
   assign mem_we  = wready && wvalid && in_rng;
   assign mem_idx = addr_q[LSB +: IDX_W];

   // R1: a raised response holds with its ID and status until taken
   p_b_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid && $stable(bid) && $stable(bresp));
   // R1: a response only appears right after a data beat handshake
   p_b_after_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bvalid) |-> $past(wvalid && wready));
endmodule

// File: rtl/axmem_rd.sv
module axmem_rd
   import axmem_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int ID_W      = 4,
   parameter int LEN_W     = 8,
   parameter int MEM_BYTES = 256,
   parameter int QDEPTH    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ID_W-1:0]     arid,
   input  logic [ADDR_W-1:0]   araddr,
   input  logic [LEN_W-1:0]    arlen,
   input  logic                arvalid,
   output logic                arready,
   output logic [ID_W-1:0]     rid,
   output logic [DATA_W-1:0]   rdata,
   output logic [1:0]          rresp,
   output logic                rlast,
   output logic                rvalid,
   input  logic                rready,
   output logic [$clog2(MEM_BYTES/(DATA_W/8))-1:0] mem_idx,
   input  logic [DATA_W-1:0]   mem_word
);
   localparam int STRB_W = DATA_W / 8;
   localparam int LSB    = $clog2(STRB_W);
   localparam int IDX_W  = $clog2(MEM_BYTES / STRB_W);
   localparam int REQ_W  = ID_W + ADDR_W + LEN_W;
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_BYTES);

   logic [REQ_W-1:0]  head;
   logic [ID_W-1:0]   h_id;
   logic [ADDR_W-1:0] h_addr, beat_addr;
   logic [LEN_W-1:0]  h_len, bcnt_q;
   logic              q_empty, q_full, load, last_b, pop, beat_in;

   axmem_rdq #(.W(REQ_W), .DEPTH(QDEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (arvalid && arready),
      .din   ({arid, araddr, arlen}),
      .pop   (pop),
      .dout  (head),
      .empty (q_empty),
      .full  (q_full)
   );

   assign {h_id, h_addr, h_len} = head;
   assign arready   = !q_full;
   assign beat_addr = h_addr + (ADDR_W'(bcnt_q) << LSB);
   assign beat_in   = ({1'b0, beat_addr} < LIMIT);
   assign load      = !q_empty && (!rvalid || rready);
   assign last_b    = (bcnt_q == h_len);
   assign pop       = load && last_b;
   assign mem_idx   = beat_addr[LSB +: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
         rresp  <= RESP_OKAY;
         rlast  <= 1'b0;
         rid    <= '0;
         bcnt_q <= '0;
      end else if (load) begin
         rvalid <= 1'b1;
         rdata  <= beat_in ? mem_word : '0;
         rresp  <= beat_in ? RESP_OKAY : RESP_SLVERR;
         rlast  <= last_b;
         rid    <= h_id;
         bcnt_q <= last_b ? '0 : bcnt_q + 1'b1;
      end else if (rready) begin
         rvalid <= 1'b0;
      end
   end

   // R10: a stalled beat keeps every field
   p_r_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rid)
                            && $stable(rresp) && $stable(rlast));
   // R4: a burst keeps streaming under its own ID until its last beat
   p_burst_cont_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && rready && !rlast |=> rvalid && $stable(rid));
endmodule

// File: rtl/axmem_slave.sv
module axmem_slave #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int ID_W      = 4,
   parameter int LEN_W     = 8,
   parameter int MEM_BYTES = 256,
   parameter int QDEPTH    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   awid,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic [LEN_W-1:0]  awlen,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic              wlast,
   input  logic              wvalid,
   output logic              wready,
   output logic [ID_W-1:0]   bid,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ID_W-1:0]   arid,
   input  logic [ADDR_W-1:0] araddr,
   input  logic [LEN_W-1:0]  arlen,
   input  logic              arvalid,
   output logic              arready,
   output logic [ID_W-1:0]   rid,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rlast,
   output logic              rvalid,
   input  logic              rready
);
   localparam int STRB_W = DATA_W / 8;
   localparam int WORDS  = MEM_BYTES / STRB_W;
   localparam int IDX_W  = $clog2(WORDS);

   if ((DATA_W % 8) != 0 || (STRB_W & (STRB_W - 1)) != 0) begin : g_bad_width
      $error("axmem_slave: DATA_W must be 8 times a power of two");
   end
   if ((MEM_BYTES % STRB_W) != 0 || (WORDS & (WORDS - 1)) != 0
       || MEM_BYTES > (1 << ADDR_W)) begin : g_bad_size
      $error("axmem_slave: MEM_BYTES must be a power-of-two word count within the address space");
   end

   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] lane_mask;
   logic [IDX_W-1:0]  w_idx, r_idx;
   logic              mem_we;

   for (genvar g = 0; g < STRB_W; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = {8{wstrb[g]}};
   end

   always_ff @(posedge clk) begin
      if (mem_we) mem[w_idx] <= (mem[w_idx] & ~lane_mask) | (wdata & lane_mask);
   end

   axmem_wr #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W),
      .LEN_W(LEN_W), .MEM_BYTES(MEM_BYTES)
   ) u_wr (
      .clk(clk), .rst_n(rst_n),
      .awid(awid), .awaddr(awaddr), .awlen(awlen),
      .awvalid(awvalid), .awready(awready),
      .wlast(wlast), .wvalid(wvalid), .wready(wready),
      .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .mem_we(mem_we), .mem_idx(w_idx)
   );

   axmem_rd #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W),
      .LEN_W(LEN_W), .MEM_BYTES(MEM_BYTES), .QDEPTH(QDEPTH)
   ) u_rd (
      .clk(clk), .rst_n(rst_n),
      .arid(arid), .araddr(araddr), .arlen(arlen),
      .arvalid(arvalid), .arready(arready),
      .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast),
      .rvalid(rvalid), .rready(rready),
      .mem_idx(r_idx), .mem_word(mem[r_idx])
   );
endmodule

// File: tb/axmem_slave_test.sv
`timescale 1ns / 1ps
module axmem_slave_test;
   localparam int MEMB = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  awid = '0, arid = '0;
   logic [11:0] awaddr = '0, araddr = '0;
   logic [7:0]  awlen = '0, arlen = '0;
   logic        awvalid = 1'b0, wvalid = 1'b0, wlast = 1'b0, bready = 1'b0;
   logic        arvalid = 1'b0, rready = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        awready, wready, bvalid, arready, rlast, rvalid;
   logic [3:0]  bid, rid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;

   int n_chk = 0, n_fail = 0;
   logic [7:0] model [MEMB];

   always #10 clk = ~clk;

   axmem_slave uut (
      .clk(clk), .rst_n(rst_n),
      .awid(awid), .awaddr(awaddr), .awlen(awlen), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
      .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .arid(arid), .araddr(araddr), .arlen(arlen), .arvalid(arvalid), .arready(arready),
      .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
   );

   typedef struct packed {
      logic [3:0]  id;
      logic [11:0] addr;
      logic [7:0]  len;
      logic [3:0]  strb;
      logic [31:0] seed;
      logic [1:0]  resp;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{4'h1, 12'h010, 8'd0, 4'b0001, 32'hA1B2C3D4, 2'b00},
      '{4'h2, 12'h020, 8'd3, 4'b1100, 32'h55667788, 2'b00},
      '{4'h3, 12'h040, 8'd2, 4'b1010, 32'hDEADBEEF, 2'b00},
      '{4'h4, 12'h060, 8'd1, 4'b0000, 32'hFFFFFFFF, 2'b00},
      '{4'h5, 12'h0F8, 8'd3, 4'b1111, 32'h0BADF00D, 2'b10},
      '{4'hF, 12'h800, 8'd0, 4'b1111, 32'h12345678, 2'b10}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int a);
      if (a >= MEMB) return 32'h0;
      return {model[a+3], model[a+2], model[a+1], model[a]};
   endfunction

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // last_at: beat index carrying wlast, or -1 for none
   task automatic wr_burst(input logic [3:0] id, input int addr, input int len, input logic [3:0] strb,
                           input logic [31:0] seed, input int last_at, input logic [1:0] exp_resp,
                           input string tag);
      int beats;
      bit hs;
      beats = (last_at >= 0 && last_at < len) ? last_at + 1 : len + 1;
      @(negedge clk);
      awid = id; awaddr = addr[11:0]; awlen = len[7:0]; awvalid = 1'b1;
      while (1) begin hs = awready; @(negedge clk); if (hs) break; end
      awvalid = 1'b0;
      for (int i = 0; i < beats; i++) begin
         logic [31:0] d;
         int a;
         d = seed + i * 32'h01010101;
         a = addr + 4 * i;
         wdata = d; wstrb = strb; wlast = (i == last_at); wvalid = 1'b1;
         if (i == 0) chk(awready == 1'b0, {tag, " R1 awready low in data phase"}, 32'(awready), 32'h0);
         while (1) begin hs = wready; @(negedge clk); if (hs) break; end
         if (a < MEMB)
            for (int b = 0; b < 4; b++) if (strb[b]) model[a+b] = d[8*b +: 8];
      end
      wvalid = 1'b0; wlast = 1'b0; bready = 1'b1;
      while (!bvalid) @(negedge clk);
      chk(bid == id, {tag, " R7 bid"}, 32'(bid), 32'(id));
      chk(bresp == exp_resp, {tag, " R8/R9 bresp"}, 32'(bresp), 32'(exp_resp));
      @(negedge clk);
      bready = 1'b0;
   endtask

   task automatic ar_send(input logic [3:0] id, input int addr, input int len);
      bit hs;
      arid = id; araddr = addr[11:0]; arlen = len[7:0]; arvalid = 1'b1;
      while (1) begin hs = arready; @(negedge clk); if (hs) break; end
      arvalid = 1'b0;
   endtask

   // collects one burst; strict = beat must already be valid (no gap)
   task automatic rd_collect(input logic [3:0] id, input int addr, input int len, input bit strict,
                             input string tag);
      for (int i = 0; i <= len; i++) begin
         int a;
         a = addr + 4 * i;
         if (strict) chk(rvalid == 1'b1, {tag, " R5 no gap"}, 32'(rvalid), 32'h1);
         while (!rvalid) @(negedge clk);
         chk(rdata == exp_word(a), {tag, " R3/R4 rdata"}, rdata, exp_word(a));
         chk(rid == id, {tag, " R7 rid"}, 32'(rid), 32'(id));
         chk(rlast == (i == len), {tag, " R4 rlast"}, 32'(rlast), 32'(i == len));
         chk(rresp == ((a < MEMB) ? 2'b00 : 2'b10), {tag, " R8 rresp"}, 32'(rresp),
             (a < MEMB) ? 32'h0 : 32'h2);
         @(negedge clk);
      end
   endtask

   task automatic rd_burst(input logic [3:0] id, input int addr, input int len, input string tag);
      @(negedge clk);
      ar_send(id, addr, len);
      rready = 1'b1;
      rd_collect(id, addr, len, 1'b0, tag);
      rready = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      finish_up();
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      chk(awready == 1'b1 && arready == 1'b1, "R11 ready after reset", {awready, arready}, 32'h3);
      chk(bvalid == 1'b0 && rvalid == 1'b0 && wready == 1'b0, "R11 valids low in reset",
          {bvalid, rvalid, wready}, 32'h0);
      rst_n = 1'b1;

      // fill the whole memory with known data
      wr_burst(4'h0, 0, 63, 4'hF, 32'h10203040, 63, 2'b00, "preload R3");
      rd_burst(4'h0, 0, 63, "preload R4");

      // table walk: strobes, lengths, ranges
      for (int k = 0; k < 6; k++) begin
         wr_burst(VECS[k].id, int'(VECS[k].addr), int'(VECS[k].len), VECS[k].strb, VECS[k].seed,
                  int'(VECS[k].len), VECS[k].resp, $sformatf("vec%0d R2", k));
         rd_burst(VECS[k].id, int'(VECS[k].addr), int'(VECS[k].len), $sformatf("vec%0d R2 R8", k));
      end

      // R9: early wlast ends burst after two beats
      wr_burst(4'h6, 32'h080, 3, 4'hF, 32'hCAFE0001, 1, 2'b10, "R9 early wlast");
      rd_burst(4'h6, 32'h080, 3, "R9 early wlast readback");
      // R9: wlast missing on final beat
      wr_burst(4'h7, 32'h0A0, 1, 4'hF, 32'hBEEF0002, -1, 2'b10, "R9 missing wlast");
      rd_burst(4'h7, 32'h0A0, 1, "R9 missing wlast readback");

      // R5/R6/R10: two queued reads, a third blocked, stalled data
      @(negedge clk);
      ar_send(4'h8, 32'h000, 3);
      ar_send(4'h9, 32'h0C0, 1);
      arid = 4'hA; araddr = 12'h010; arlen = 8'd0; arvalid = 1'b1;
      chk(arready == 1'b0, "R6 arready low when full", 32'(arready), 32'h0);
      held = rdata;
      chk(rvalid == 1'b1, "R10 beat pending", 32'(rvalid), 32'h1);
      repeat (3) @(negedge clk);
      chk(rvalid == 1'b1 && rdata == held, "R10 stalled data held", rdata, held);
      chk(arready == 1'b0, "R6 arready still low", 32'(arready), 32'h0);
      rready = 1'b1;
      fork
         begin
            while (!arready) @(negedge clk);
            @(negedge clk);
            arvalid = 1'b0;
         end
         begin
            rd_collect(4'h8, 32'h000, 3, 1'b1, "R5 first");
            rd_collect(4'h9, 32'h0C0, 1, 1'b1, "R5 second");
            rd_collect(4'hA, 32'h010, 0, 1'b0, "R5 R6 third");
         end
      join
      rready = 1'b0;

      // R11: reset mid-stream keeps memory
      wr_burst(4'hB, 32'h0C8, 0, 4'hF, 32'h5A5A1234, 0, 2'b00, "R11 setup");
      @(negedge clk);
      ar_send(4'hC, 32'h0C0, 7);
      while (!rvalid) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(rvalid == 1'b0 && bvalid == 1'b0 && wready == 1'b0, "R11 async clear",
          {rvalid, bvalid, wready}, 32'h0);
      chk(arready == 1'b1 && awready == 1'b1, "R11 queue emptied", {arready, awready}, 32'h3);
      @(negedge clk);
      rst_n = 1'b1;
      rready = 1'b1;
      repeat (3) @(negedge clk);
      chk(rvalid == 1'b0, "R11 pending reads dropped", 32'(rvalid), 32'h0);
      rready = 1'b0;
      rd_burst(4'hD, 32'h0C8, 0, "R11 memory kept");

      finish_up();
   end
endmodule